// File: doc/BRIEF.md
# Filtered Address-Swap Loopback

This block sits in a 100 Gb/s data path between an Ethernet receive stream and a transmit stream. Frames arrive as 512-bit AXI4-Stream beats, with the first wire byte in the lowest byte lane. On the first beat of each frame, a layer-2 filter compares the destination MAC address with a programmed address. A frame that fails the filter is consumed in full and never appears on the output. A frame that passes is sent back with its two MAC addresses exchanged. If its EtherType marks it as IPv4, its two IPv4 addresses are exchanged too. The IPv4 header checksum is a one's-complement sum, so swapping two of its words leaves it valid, and the block passes the checksum through untouched.

Per-frame metadata on TUSER trails the data and is meaningful only with TLAST. It travels with each beat, so the output metadata appears on the final output beat. A 32-bit AXI4-Lite slave holds the filter settings and three statistics counters. A shared snapshot pulse copies all three counters into shadow registers at the same instant, and software reads the shadows. After reset the block is running but the filter is disabled, so it matches no frame until software enables it.

Top module: `addr_swap_loopback`

## Requirements
- R1: After reset the output is idle, the filter enable is 0 and the statistics shadows read 0. While the enable is 0, no frame reaches the output, whatever its addresses.
- R2: A frame is looped only when the enable (control register 0x00 bit 0) is 1 and destination bytes 0..5 equal the programmed address. The programmed address is held big-endian: register 0x04 bits 15:8 hold byte 0 and bits 7:0 hold byte 1. Register 0x08 holds byte 2 in bits 31:24 down to byte 5 in bits 7:0. Every beat of a rejected frame is consumed and none is output.
- R3: On the first beat of every looped frame, bytes 0..5 and bytes 6..11 are exchanged.
- R4: When bytes 12 and 13 are 0x08 and 0x00, bytes 26..29 and bytes 30..33 are also exchanged on the first beat. All other bytes, including the IPv4 checksum, are unchanged.
- R5: A looped frame with any other EtherType has only its MAC addresses exchanged.
- R6: Beats after the first pass unchanged. TKEEP, TLAST and TUSER pass with their beat, so the metadata on the final beat is preserved.
- R7: While output TVALID is high and TREADY is low, the output beat is held stable. Input TREADY is high exactly when the output register is empty or is being drained. Each beat passes through one register stage.
- R8: Writes to registers 0x00, 0x04 and 0x08 are read back unchanged. Reads of unused addresses return 0. Responses are OKAY.
- R9: Frames received, frames rejected and frames looped are counted by their first beats. On a pulse of the snapshot input, all three counts are copied into shadows. The shadows are read at 0x0C (received), 0x10 (rejected) and 0x14 (looped), and they keep their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_tdata | input | DATA_W | Input beat data, byte 0 in bits 7:0 |
| in_tkeep | input | DATA_W/8 | Input byte enables |
| in_tuser | input | USER_W | Input metadata, valid with in_tlast |
| in_tlast | input | 1 | Input last beat of a frame |
| in_tvalid | input | 1 | Input beat valid |
| in_tready | output | 1 | Input beat accepted |
| out_tdata | output | DATA_W | Output beat data |
| out_tkeep | output | DATA_W/8 | Output byte enables |
| out_tuser | output | USER_W | Output metadata, valid with out_tlast |
| out_tlast | output | 1 | Output last beat |
| out_tvalid | output | 1 | Output beat valid |
| out_tready | input | 1 | Downstream ready |
| stat_snap | input | 1 | Snapshot pulse for the statistics |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
If the flag that tracks the middle of a frame goes wrong, a later beat is taken for a header. That beat is then filtered or swapped, and the error shows one cycle later as a corrupted byte at offsets 0..33, or as a beat that is dropped or added, at the frame's next beat. A wrong keep flag for the frame turns into missing or extra output beats, which are caught when the expected-beat queue fails to drain. Counter or shadow faults stay hidden until the next snapshot and read, so the statistics are read after every sweep.

// File: rtl/addr_swap_loopback.sv
module addr_swap_loopback #(
  parameter int DATA_W = 512,
  parameter int USER_W = 8,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   in_tdata,
  input  logic [DATA_W/8-1:0] in_tkeep,
  input  logic [USER_W-1:0]   in_tuser,
  input  logic                in_tlast,
  input  logic                in_tvalid,
  output logic                in_tready,
  output logic [DATA_W-1:0]   out_tdata,
  output logic [DATA_W/8-1:0] out_tkeep,
  output logic [USER_W-1:0]   out_tuser,
  output logic                out_tlast,
  output logic                out_tvalid,
  input  logic                out_tready,
  input  logic                stat_snap,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [31:0]         s_wdata,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [31:0]         s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready
);
  localparam int KEEP_W = DATA_W / 8;

  logic        cfg_en;
  logic [15:0] mac_hi;
  logic [31:0] mac_lo;
  logic [47:0] cfg_mac;
  logic        mid, keep_q;
  logic        mac_ok, is_ip4, pass, in_hs;
  logic [DATA_W-1:0] swapped;
  logic [CNT_W-1:0] n_rx, n_rej, n_loop, sh_rx, sh_rej, sh_loop;

  assign cfg_mac   = {mac_hi, mac_lo};
  assign in_tready = !out_tvalid || out_tready;
  assign in_hs     = in_tvalid && in_tready;
  assign is_ip4    = in_tdata[103:96] == 8'h08 && in_tdata[111:104] == 8'h00;
  assign pass      = mid ? keep_q : (cfg_en && mac_ok);

  always_comb begin
    mac_ok = 1'b1;
    for (int i = 0; i < 6; i++)
      if (in_tdata[8*i +: 8] != cfg_mac[8*(5-i) +: 8]) mac_ok = 1'b0;
  end

  always_comb begin
    swapped = in_tdata;
    for (int i = 0; i < 6; i++) begin
      swapped[8*i +: 8]     = in_tdata[8*(i+6) +: 8];
      swapped[8*(i+6) +: 8] = in_tdata[8*i +: 8];
    end
    if (is_ip4)
      for (int i = 0; i < 4; i++) begin
        swapped[8*(26+i) +: 8] = in_tdata[8*(30+i) +: 8];
        swapped[8*(30+i) +: 8] = in_tdata[8*(26+i) +: 8];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_tvalid <= 1'b0;
      out_tdata  <= '0;
      out_tkeep  <= '0;
      out_tuser  <= '0;
      out_tlast  <= 1'b0;
      mid        <= 1'b0;
      keep_q     <= 1'b0;
    end else begin
      if (in_tready) out_tvalid <= in_hs && pass;
      if (in_hs) begin
        mid <= !in_tlast;
        if (!mid) keep_q <= cfg_en && mac_ok;
        if (pass) begin
          out_tdata <= mid ? in_tdata : swapped;
          out_tkeep <= in_tkeep;
          out_tuser <= in_tuser;
          out_tlast <= in_tlast;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {n_rx, n_rej, n_loop}    <= '0;
      {sh_rx, sh_rej, sh_loop} <= '0;
    end else begin
      if (in_hs && !mid) begin
        n_rx <= n_rx + 1'b1;
        if (cfg_en && mac_ok) n_loop <= n_loop + 1'b1;
        else                  n_rej  <= n_rej + 1'b1;
      end
      if (stat_snap) {sh_rx, sh_rej, sh_loop} <= {n_rx, n_rej, n_loop};
    end
  end

  logic wr_go;
  assign wr_go     = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign s_arready = !s_rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      mac_hi   <= '0;
      mac_lo   <= '0;
      s_bvalid <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      if (wr_go) begin
        s_bvalid <= 1'b1;
        case (s_awaddr[ADDR_W-1:2])
          3'd0: cfg_en <= s_wdata[0];
          3'd1: mac_hi <= s_wdata[15:0];
          3'd2: mac_lo <= s_wdata;
          default: ;
        endcase
      end else if (s_bready) s_bvalid <= 1'b0;
      if (s_arvalid && s_arready) begin
        s_rvalid <= 1'b1;
        case (s_araddr[ADDR_W-1:2])
          3'd0: s_rdata <= {31'd0, cfg_en};
          3'd1: s_rdata <= {16'd0, mac_hi};
          3'd2: s_rdata <= mac_lo;
          3'd3: s_rdata <= 32'(sh_rx);
          3'd4: s_rdata <= 32'(sh_rej);
          3'd5: s_rdata <= 32'(sh_loop);
          default: s_rdata <= '0;
        endcase
      end else if (s_rready) s_rvalid <= 1'b0;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata) && $stable(out_tlast) && $stable(out_tuser));
  assert_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_tvalid) |-> $past(in_tvalid && in_tready));
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (n_rx == $past(n_rx)) || (n_rx == $past(n_rx) + 1'b1));
  assert_count_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    n_rx == n_rej + n_loop);
  assert_bhold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  assert_rhold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
endmodule

// File: tb/test_addr_swap_loopback.sv
module test_addr_swap_loopback;
  localparam int DW = 512, KW = 64, UW = 8, AW = 5;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] in_tdata = '0, out_tdata;
  logic [KW-1:0] in_tkeep = '0, out_tkeep;
  logic [UW-1:0] in_tuser = '0, out_tuser;
  logic in_tlast = 0, in_tvalid = 0, in_tready, out_tlast, out_tvalid, out_tready = 1, stat_snap = 0;
  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_awready, s_wvalid = 0, s_wready, s_bvalid, s_bready = 1;
  logic s_arvalid = 0, s_arready, s_rvalid, s_rready = 1;
  logic [31:0] s_wdata = '0, s_rdata;
  logic [1:0] s_bresp, s_rresp;

  always #5 clk = ~clk;

  addr_swap_loopback i_addr_swap_loopback (.*);

  int checks = 0, fails = 0, outs = 0, cyc = 0;
  logic stall_mode = 0;
  logic [DW-1:0] q_data [0:511];
  logic [KW-1:0] q_keep [0:511];
  logic [UW-1:0] q_user [0:511];
  logic          q_last [0:511];
  logic          q_first[0:511];
  logic          q_ip4  [0:511];
  int wp = 0, rp = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    out_tready <= stall_mode ? ((cyc % 5) != 3 && (cyc % 7) != 0) : 1'b1;
  end

  logic prev_stall = 0;
  logic [DW-1:0] prev_data;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall) begin
        chk("R7 held valid", DW'(out_tvalid), DW'(1));
        chk("R7 held data", out_tdata, prev_data);
      end
      if (out_tvalid && out_tready) begin
        outs++;
        if (rp == wp) chk("R2 unexpected beat", DW'(1), DW'(0));
        else begin
          if (q_first[rp]) begin
            chk("R3 mac swap", DW'(out_tdata[95:0]), DW'(q_data[rp][95:0]));
            chk(q_ip4[rp] ? "R4 ip swap" : "R5 mac only", out_tdata, q_data[rp]);
          end else chk("R6 later beat", out_tdata, q_data[rp]);
          chk("R6 sideband", DW'({out_tkeep, out_tuser, out_tlast}),
              DW'({q_keep[rp], q_user[rp], q_last[rp]}));
          rp++;
        end
      end
      prev_stall = out_tvalid && !out_tready;
      prev_data  = out_tdata;
    end
  end

  task automatic axw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
    #4; while (!s_awready) begin @(negedge clk); #4; end
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
  endtask

  task automatic axr(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    #4; while (!s_arready) begin @(negedge clk); #4; end
    @(negedge clk);
    s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    axr(a, d);
    chk(req, DW'(d), DW'(exp));
  endtask

  task automatic send(input int f, input logic [47:0] dst, input logic [15:0] et,
                      input int nb, input logic expect_out);
    for (int b = 0; b < nb; b++) begin
      logic [DW-1:0] d, e;
      for (int j = 0; j < 16; j++) d[32*j +: 32] = {8'(f), 8'(b), 8'(j), 8'hA5};
      if (b == 0) begin
        for (int i = 0; i < 6; i++) begin
          d[8*i +: 8]     = dst[8*(5-i) +: 8];
          d[8*(i+6) +: 8] = 8'(8'h60 + f + i);
        end
        d[103:96] = et[15:8]; d[111:104] = et[7:0];
      end
      e = d;
      if (b == 0) begin
        for (int i = 0; i < 6; i++) begin
          e[8*i +: 8] = d[8*(i+6) +: 8]; e[8*(i+6) +: 8] = d[8*i +: 8];
        end
        if (et == 16'h0800)
          for (int i = 0; i < 4; i++) begin
            e[8*(26+i) +: 8] = d[8*(30+i) +: 8]; e[8*(30+i) +: 8] = d[8*(26+i) +: 8];
          end
      end
      if (expect_out) begin
        q_data[wp] = e; q_first[wp] = (b == 0); q_ip4[wp] = (et == 16'h0800);
        q_last[wp] = (b == nb - 1);
        q_keep[wp] = (b == nb - 1) ? ({KW{1'b1}} >> (f % 40)) : {KW{1'b1}};
        q_user[wp] = (b == nb - 1) ? UW'(f + 1) : '0;
        wp++;
      end
      @(negedge clk);
      in_tdata = d; in_tvalid = 1; in_tlast = (b == nb - 1);
      in_tkeep = (b == nb - 1) ? ({KW{1'b1}} >> (f % 40)) : {KW{1'b1}};
      in_tuser = (b == nb - 1) ? UW'(f + 1) : '0;
      #4; while (!in_tready) begin @(negedge clk); #4; end
    end
    @(negedge clk);
    in_tvalid = 0; in_tlast = 0;
  endtask

  task automatic snap;
    @(negedge clk); stat_snap = 1;
    @(negedge clk); stat_snap = 0;
  endtask

  localparam logic [47:0] MY_MAC = 48'h02_11_22_33_44_55;

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL R7 watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int nrx, nrej, nloop, f;
    logic [47:0] dsts [0:3];
    logic [15:0] ets  [0:3];
    nrx = 0; nrej = 0; nloop = 0; f = 0;
    dsts[0] = MY_MAC; dsts[1] = MY_MAC ^ 48'h01_00_00_00_00_00;
    dsts[2] = MY_MAC ^ 48'h00_00_00_00_00_80; dsts[3] = 48'hFF_FF_FF_FF_FF_FF;
    ets[0] = 16'h0800; ets[1] = 16'h0806; ets[2] = 16'h0801; ets[3] = 16'h0008;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out idle", DW'(out_tvalid), DW'(0));
    rd_chk("R1 enable reset", 5'h00, 32'd0);
    rd_chk("R1 shadow rx reset", 5'h0C, 32'd0);
    rd_chk("R1 shadow looped reset", 5'h14, 32'd0);

    axw(5'h04, 32'h0000_0211);
    axw(5'h08, 32'h2233_4455);
    for (int k = 0; k < 4; k++) begin
      send(f, MY_MAC, ets[k], 1 + k % 3, 1'b0); f++; nrx++; nrej++;
    end
    repeat (4) @(negedge clk);
    chk("R1 nothing looped while disabled", DW'(outs), DW'(0));

    axw(5'h00, 32'h1);
    rd_chk("R8 enable readback", 5'h00, 32'h1);
    rd_chk("R8 mac hi readback", 5'h04, 32'h0211);
    rd_chk("R8 mac lo readback", 5'h08, 32'h2233_4455);
    rd_chk("R8 unused reads zero", 5'h18, 32'd0);

    for (int s = 0; s < 2; s++) begin
      stall_mode = (s == 1);
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 4; k++)
          for (int nb = 1; nb <= 3; nb++) begin
            send(f, dsts[m], ets[k], nb, m == 0);
            f++; nrx++;
            if (m == 0) nloop++; else nrej++;
          end
    end
    stall_mode = 0;
    repeat (10) @(negedge clk);
    chk("R2 all expected beats seen", DW'(rp), DW'(wp));

    rd_chk("R9 shadow before snapshot", 5'h0C, 32'd0);
    snap;
    rd_chk("R9 received", 5'h0C, 32'(nrx));
    rd_chk("R9 rejected", 5'h10, 32'(nrej));
    rd_chk("R9 looped", 5'h14, 32'(nloop));
    send(f, MY_MAC, 16'h0800, 2, 1'b1); f++;
    repeat (4) @(negedge clk);
    rd_chk("R9 shadow frozen until next pulse", 5'h0C, 32'(nrx));
    snap;
    rd_chk("R9 received after second pulse", 5'h0C, 32'(nrx + 1));

    axw(5'h00, 32'h0);
    send(f, MY_MAC, 16'h0800, 2, 1'b0); f++;
    repeat (6) @(negedge clk);
    chk("R2 disabled again drops", DW'(rp), DW'(wp));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule